// File: doc/BRIEF.md
# Receive Byte Reorder and Delimiter Hunter

This block is the first stage of a wake-on-LAN receive path. It takes received bytes one per strobe, together with a frame-active level. Before any comparison it rearranges each byte in one of four ways: unchanged, fully bit-reversed, nibble-swapped, or bit-reversed inside each nibble. This lets the same logic sit behind a PHY whose data lanes come out in an unusual order.

The reordered stream is searched for a start-of-frame delimiter. The delimiter is 0xD5 by default, or 0x5D when the alternate select is set. At the first match in a frame the block gives a one-cycle start pulse. It then forwards every later valid byte of that frame as payload. When frame-active drops, forwarding stops and the search arms again. The ordering and delimiter controls are latched only while no frame is active, so a frame is always handled with one consistent setting.

Top module: `rxfe_sfd_front`

## Requirements
- R1: After reset `sof_pulse` and `pay_valid` are 0 and `pay_data` is 0. The latched configuration is order code 00 with delimiter select 0, and it stays so until frame-active is first seen low.
- R2: Order code 00 keeps each byte unchanged: output bit i equals input bit i.
- R3: Order code 01 reverses the whole byte: output bit i equals input bit 7-i.
- R4: Order code 10 exchanges the nibbles: output bits 7:4 equal input bits 3:0, and output bits 3:0 equal input bits 7:4.
- R5: Order code 11 reverses bits inside each nibble: output bit 7,6,5,4 equal input bit 4,5,6,7, and output bit 3,2,1,0 equal input bit 0,1,2,3.
- R6: The delimiter is compared after reordering. It is 0xD5 when the delimiter select is 0 and 0x5D when it is 1.
- R7: A byte accepted at clock edge k that matches the delimiter raises `sof_pulse` for exactly the cycle after edge k+1. The delimiter byte itself is never forwarded.
- R8: Only the first delimiter match in a frame pulses `sof_pulse`. Later bytes equal to the delimiter are forwarded as ordinary payload.
- R9: Bytes before the delimiter are never forwarded. A frame without a delimiter produces no pulse and no payload.
- R10: Payload byte accepted at edge k appears on `pay_data` with `pay_valid` high after edge k+1, in arrival order. Strobes seen while frame-active is low are ignored. After frame-active drops the search re-arms for the next frame.
- R11: Changes to `cfg_order` or `cfg_sfd_alt` while frame-active is high have no effect on the current frame. They apply from the next frame onward.
- R12: A cycle with `rx_valid` low, inside a frame, produces no payload and no pulse, and does not break the byte sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received byte, raw lane order |
| rx_valid | input | 1 | `rx_data` holds a byte this cycle |
| rx_frame | input | 1 | High for the duration of a received frame |
| cfg_order | input | 2 | Byte reorder code (00 pass, 01 full reverse, 10 nibble swap, 11 per-nibble reverse) |
| cfg_sfd_alt | input | 1 | Delimiter select: 0 for 0xD5, 1 for 0x5D |
| sof_pulse | output | 1 | One-cycle pulse on first delimiter match in a frame |
| pay_data | output | 8 | Reordered payload byte |
| pay_valid | output | 1 | `pay_data` holds a payload byte this cycle |

## Verification
The bench goes after delimiter bytes that only match once they are reordered. A design that compares raw bytes, or picks the wrong code-to-mapping pairing, would miss the match or lock onto the wrong byte. Frames with a second delimiter, with none, and with gaps in the strobe catch a hunter that pulses twice, leaks preamble bytes, or loses bytes in the gaps. Changing the controls in mid-frame, keeping frame-active high through reset release, and strobing bytes between frames show whether the configuration is latched only at frame boundaries, whether it resets to its defaults, and whether stray strobes can start a frame.

// File: rtl/rxfe_pkg.sv
// Shared types for the receive front end: reorder codes and hunter states.
package rxfe_pkg;

    // Byte reorder selection; the encoding matches the cfg_order port.
    typedef enum logic [1:0] {
        ORD_PASS    = 2'b00,
        ORD_BITREV  = 2'b01,
        ORD_NIBSWAP = 2'b10,
        ORD_NIBREV  = 2'b11
    } rxfe_order_e;

    // Hunter states: looking for the delimiter, or forwarding payload.
    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_FWD  = 1'b1
    } rxfe_state_e;

endpackage

// File: rtl/rxfe_cfg_hold.sv
// Configuration holder.
// Copies the order code and delimiter select from the inputs on every cycle
// in which no frame is active, and freezes them while a frame is active.
// Assumes frame-active is low for at least one clock between frames.
module rxfe_cfg_hold
    import rxfe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_in,
    input  logic [1:0]  order_in,
    input  logic        alt_in,
    output rxfe_order_e order_q,
    output logic        alt_q
);

    // Sample the controls only outside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= ORD_PASS;
            alt_q   <= 1'b0;
        end else if (!frame_in) begin
            order_q <= rxfe_order_e'(order_in);
            alt_q   <= alt_in;
        end
    end

    // R11: the latched configuration cannot move while a frame is active.
    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_in |=> ($stable(order_q) && $stable(alt_q)));

endmodule

// File: rtl/rxfe_reorder_stage.sv
// Reorder stage.
// Builds the four bit arrangements of the incoming byte, selects one by the
// latched order code, and registers the result with a qualified strobe and
// a delayed copy of frame-active. Assumes BYTE_W is even.
module rxfe_reorder_stage
    import rxfe_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rxfe_order_e       order,
    input  logic [BYTE_W-1:0] din,
    input  logic              din_valid,
    input  logic              din_frame,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_valid,
    output logic              dout_frame
);

    localparam int NIB_W = BYTE_W / 2;

    logic [BYTE_W-1:0] map_rev;
    logic [BYTE_W-1:0] map_swap;
    logic [BYTE_W-1:0] map_nrev;
    logic [BYTE_W-1:0] mapped;
    logic              take;

    // One wiring slice per output bit for each arrangement.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign map_rev[i]  = din[BYTE_W-1-i];
        assign map_swap[i] = din[(i + NIB_W) % BYTE_W];
        assign map_nrev[i] = din[(i / NIB_W) * NIB_W + (NIB_W - 1 - (i % NIB_W))];
    end

    // Select the arrangement named by the order code.
    always_comb begin
        unique case (order)
            ORD_PASS:    mapped = din;
            ORD_BITREV:  mapped = map_rev;
            ORD_NIBSWAP: mapped = map_swap;
            ORD_NIBREV:  mapped = map_nrev;
            default:     mapped = din;
        endcase
    end

    assign take = din_valid && din_frame;

    // Register the reordered byte; strobes outside a frame are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
            dout_frame <= 1'b0;
        end else begin
            dout_valid <= take;
            dout_frame <= din_frame;
            if (take) begin
                dout <= mapped;
            end
        end
    end

    // R12 / R10: an idle or out-of-frame strobe never yields a staged byte.
    assert_no_stray_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(din_valid && din_frame) |=> !dout_valid);

    // R10: a staged byte always belongs to an active frame.
    assert_staged_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> dout_frame);

endmodule

// File: rtl/rxfe_sfd_hunt.sv
// Delimiter hunter.
// Compares staged bytes with the selected delimiter. On the first match it
// pulses the start output and switches to forwarding, passing each later
// byte out as payload. It returns to hunting once the staged frame-active
// copy is low. Assumes staged strobes occur only inside a frame.
module rxfe_sfd_hunt
    import rxfe_pkg::*;
#(
    parameter int              BYTE_W  = 8,
    parameter logic [BYTE_W-1:0] SFD_PRI = 8'hD5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_sel,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_valid,
    input  logic              byte_frame,
    output logic              sof,
    output logic [BYTE_W-1:0] pay_data,
    output logic              pay_valid
);

    localparam int                NIB_W   = BYTE_W / 2;
    localparam logic [BYTE_W-1:0] SFD_ALT = {SFD_PRI[NIB_W-1:0], SFD_PRI[BYTE_W-1:NIB_W]};

    rxfe_state_e       state_q;
    logic [BYTE_W-1:0] target;
    logic              hit;

    // Pick the delimiter value for the current frame.
    always_comb begin
        target = alt_sel ? SFD_ALT : SFD_PRI;
        hit    = byte_valid && (byte_in == target);
    end

    // Hunt/forward sequencing with registered pulse and payload outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_HUNT;
            sof       <= 1'b0;
            pay_data  <= '0;
            pay_valid <= 1'b0;
        end else begin
            sof       <= 1'b0;
            pay_valid <= 1'b0;
            unique case (state_q)
                ST_HUNT: begin
                    if (hit) begin
                        sof     <= 1'b1;
                        state_q <= ST_FWD;
                    end
                end
                ST_FWD: begin
                    if (byte_valid) begin
                        pay_valid <= 1'b1;
                        pay_data  <= byte_in;
                    end
                    if (!byte_frame) begin
                        state_q <= ST_HUNT;
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    // R7: the start indication lasts one cycle.
    assert_sof_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof);

    // R8: no second start indication while forwarding the same frame.
    assert_single_sof_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FWD) |=> !sof);

    // R9: payload is only emitted after a delimiter was found.
    assert_pay_after_sfd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> (state_q == ST_FWD));

    // R10: a frame end re-arms the search.
    assert_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_frame |=> (state_q == ST_HUNT));

endmodule

// File: rtl/rxfe_sfd_front.sv
// Receive front end top.
// Chains the configuration holder, the reorder stage and the delimiter
// hunter. Output latency is two clocks from an accepted byte.
// Assumes frame-active is low for at least one clock between frames.
module rxfe_sfd_front
    import rxfe_pkg::*;
#(
    parameter int                BYTE_W  = 8,
    parameter logic [BYTE_W-1:0] SFD_PRI = 8'hD5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              rx_frame,
    input  logic [1:0]        cfg_order,
    input  logic              cfg_sfd_alt,
    output logic              sof_pulse,
    output logic [BYTE_W-1:0] pay_data,
    output logic              pay_valid
);

    rxfe_order_e       order_q;
    logic              alt_q;
    logic [BYTE_W-1:0] stg_byte;
    logic              stg_valid;
    logic              stg_frame;

    rxfe_cfg_hold u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_in (rx_frame),
        .order_in (cfg_order),
        .alt_in   (cfg_sfd_alt),
        .order_q  (order_q),
        .alt_q    (alt_q)
    );

    rxfe_reorder_stage #(
        .BYTE_W (BYTE_W)
    ) u_reorder (
        .clk        (clk),
        .rst_n      (rst_n),
        .order      (order_q),
        .din        (rx_data),
        .din_valid  (rx_valid),
        .din_frame  (rx_frame),
        .dout       (stg_byte),
        .dout_valid (stg_valid),
        .dout_frame (stg_frame)
    );

    rxfe_sfd_hunt #(
        .BYTE_W  (BYTE_W),
        .SFD_PRI (SFD_PRI)
    ) u_hunt (
        .clk        (clk),
        .rst_n      (rst_n),
        .alt_sel    (alt_q),
        .byte_in    (stg_byte),
        .byte_valid (stg_valid),
        .byte_frame (stg_frame),
        .sof        (sof_pulse),
        .pay_data   (pay_data),
        .pay_valid  (pay_valid)
    );

    // R1 / R9: outputs stay quiet in the cycle right after reset.
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!sof_pulse && !pay_valid));

endmodule

// File: tb/test_rxfe_sfd_front.sv
// Self-checking bench: directed corner cases plus seeded random frames.
module test_rxfe_sfd_front;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0;
    logic       rx_frame = 1'b0;
    logic [1:0] cfg_order = 2'b00;
    logic       cfg_sfd_alt = 1'b0;
    logic       sof_pulse;
    logic [7:0] pay_data;
    logic       pay_valid;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [7:0] got_q[$];
    int         sof_q[$];

    rxfe_sfd_front i_rxfe_sfd_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .rx_frame    (rx_frame),
        .cfg_order   (cfg_order),
        .cfg_sfd_alt (cfg_sfd_alt),
        .sof_pulse   (sof_pulse),
        .pay_data    (pay_data),
        .pay_valid   (pay_valid)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Collect outputs half a period after the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sof_pulse) sof_q.push_back(cyc);
            if (pay_valid) got_q.push_back(pay_data);
        end
    end

    function automatic logic [7:0] ref_order(input logic [7:0] b, input logic [1:0] code);
        logic [7:0] r;
        case (code)
            2'b00: r = b;
            2'b01: for (int k = 0; k < 8; k++) r[k] = b[7-k];
            2'b10: r = {b[3:0], b[7:4]};
            default: r = {b[4], b[5], b[6], b[7], b[0], b[1], b[2], b[3]};
        endcase
        return r;
    endfunction

    function automatic logic [7:0] ref_sfd(input logic alt);
        return alt ? 8'h5D : 8'hD5;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] o, input logic a);
        @(negedge clk);
        cfg_order   = o;
        cfg_sfd_alt = a;
        repeat (2) @(negedge clk);
    endtask

    // Drive one frame and compare what comes out with the bench model.
    task automatic send_frame(input logic [7:0] raw[$], input bit gaps,
                              input bit mid_chg, input logic [1:0] m_ord,
                              input logic m_alt, input string req);
        logic [7:0] exp_q[$];
        int         exp_sof = -1;
        bit         found = 0;
        logic [7:0] ob;
        got_q.delete();
        sof_q.delete();
        @(negedge clk);
        rx_frame = 1'b1;
        for (int i = 0; i < raw.size(); i++) begin
            if (mid_chg && i == raw.size() / 2) begin
                cfg_order   = ~m_ord;
                cfg_sfd_alt = ~m_alt;
            end
            if (gaps && ($urandom % 3 == 0)) begin
                rx_valid = 1'b0;
                rx_data  = 8'($urandom);
                @(negedge clk);
            end
            rx_valid = 1'b1;
            rx_data  = raw[i];
            ob = ref_order(raw[i], m_ord);
            if (!found && ob == ref_sfd(m_alt)) begin
                found   = 1;
                exp_sof = cyc + 2;
            end else if (found) begin
                exp_q.push_back(ob);
            end
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_frame = 1'b0;
        repeat (4) @(negedge clk);
        check(sof_q.size() == (found ? 1 : 0), req, "start pulse count",
              sof_q.size(), found ? 1 : 0);
        if (found && sof_q.size() == 1)
            check(sof_q[0] == exp_sof, req, "start pulse cycle", sof_q[0], exp_sof);
        check(got_q.size() == exp_q.size(), req, "payload length",
              got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check(got_q[i] == exp_q[i], req, "payload byte", got_q[i], exp_q[i]);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] fr[$];
        void'($urandom(32'h1d5a));

        // R1: hold frame-active through reset release with non-default controls.
        cfg_order   = 2'b11;
        cfg_sfd_alt = 1'b1;
        rx_frame    = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(sof_pulse == 1'b0, "R1", "sof after reset", sof_pulse, 0);
        check(pay_valid == 1'b0, "R1", "pay_valid after reset", pay_valid, 0);
        check(pay_data == 8'h00, "R1", "pay_data after reset", pay_data, 0);
        // R1: defaults (pass-through, 0xD5) govern the frame already open.
        fr = '{8'h55, 8'hD5, 8'h3C, 8'h81};
        send_frame(fr, 0, 0, 2'b00, 1'b0, "R1");

        // R2 R3 R4 R5 R6: every order code with both delimiter values.
        for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 2; a++) begin
                set_cfg(2'(c), 1'(a));
                fr = '{8'h55, 8'h55,
                       ref_order(ref_sfd(1'(a)), 2'(c)),
                       8'h1E, 8'hA0, 8'h37, 8'hC4};
                case (c)
                    0: send_frame(fr, 0, 0, 2'(c), 1'(a), "R2/R6");
                    1: send_frame(fr, 0, 0, 2'(c), 1'(a), "R3/R6");
                    2: send_frame(fr, 0, 0, 2'(c), 1'(a), "R4/R6");
                    default: send_frame(fr, 0, 0, 2'(c), 1'(a), "R5/R6");
                endcase
            end
        end

        // R6: raw 0xD5 under order 01 becomes 0xAB and must not match.
        set_cfg(2'b01, 1'b0);
        fr = '{8'hD5, 8'h12, 8'h34};
        send_frame(fr, 0, 0, 2'b01, 1'b0, "R6");

        // R8: a second delimiter inside the payload is plain data.
        set_cfg(2'b00, 1'b0);
        fr = '{8'h55, 8'hD5, 8'h01, 8'hD5, 8'h02, 8'hD5};
        send_frame(fr, 0, 0, 2'b00, 1'b0, "R8");

        // R9: a frame with no delimiter yields nothing.
        fr = '{8'h55, 8'h55, 8'h5D, 8'hAB, 8'h00};
        send_frame(fr, 0, 0, 2'b00, 1'b0, "R9");

        // R7: delimiter as the last byte gives a pulse and no payload.
        fr = '{8'h55, 8'hD5};
        send_frame(fr, 0, 0, 2'b00, 1'b0, "R7");

        // R10: strobes with frame-active low are ignored.
        got_q.delete();
        sof_q.delete();
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = 8'hD5;
        @(negedge clk);
        rx_data  = 8'h77;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(sof_q.size() == 0, "R10", "pulse from out-of-frame strobe", sof_q.size(), 0);
        check(got_q.size() == 0, "R10", "payload from out-of-frame strobe", got_q.size(), 0);
        // R10: search re-armed, next frame still found.
        fr = '{8'h55, 8'hD5, 8'h99};
        send_frame(fr, 0, 0, 2'b00, 1'b0, "R10");

        // R11: controls changed mid-frame do not touch the current frame.
        set_cfg(2'b10, 1'b0);
        fr = '{8'h55, 8'h5D, 8'h11, 8'h22, 8'h5D, 8'h33};
        send_frame(fr, 0, 1, 2'b10, 1'b0, "R11");
        // R11: next frame uses the new settings (order 01, select 1).
        fr = '{8'h55, ref_order(8'h5D, 2'b01), 8'h44, 8'h66};
        send_frame(fr, 0, 0, 2'b01, 1'b1, "R11");

        // R12: idle strobe cycles inside a frame.
        set_cfg(2'b11, 1'b1);
        fr = '{8'h55, ref_order(8'h5D, 2'b11), 8'h10, 8'h20, 8'h30, 8'h40, 8'h50};
        send_frame(fr, 1, 0, 2'b11, 1'b1, "R12");

        // Random frames across all settings, R2..R10 and R12.
        for (int n = 0; n < 40; n++) begin
            logic [1:0] o;
            logic       a;
            int         len;
            o   = 2'($urandom);
            a   = 1'($urandom);
            set_cfg(o, a);
            fr.delete();
            len = 1 + $urandom % 6;
            for (int i = 0; i < len; i++) fr.push_back(8'($urandom));
            if ($urandom % 4 != 0) fr.push_back(ref_order(ref_sfd(a), o));
            len = $urandom % 10;
            for (int i = 0; i < len; i++) fr.push_back(8'($urandom));
            send_frame(fr, 1'($urandom), 0, o, a, "R2-random/R12");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule